// File: doc/BRIEF.md
# Cartridge RAM Map Control Decoder

This block sits on the cartridge side of an 8-bit host bus with 16-bit addresses. It watches the bus for writes to two pairs of soft-switch addresses. One pair arms or disarms an external memory map. The other pair mirrors the map-type bit of the host memory controller. While the external map is armed and the controller is in map type 0, the block claims the upper address range for a 32K external RAM. It drives the RAM chip-select, write-enable and offset address, and it pulls an active-low line that stops internal ROM and device decoding.

The block snoops the bus and drives control lines. It does not move data, so there is no valid/ready interface and every pin is a plain level. A bus cycle is a write when `bus_rd_wr_n` is low. The cycle is in its data phase when `bus_e` is high. The soft-switch registers sample on the rising edge of `clk` while a write is in its data phase. Writing the same switch again in the same cycle has no further effect, so the number of `clk` edges inside the data phase does not matter. The decode outputs are combinational from the address and the registered flags.

Top module: `cart_map_ctrl`

## Requirements
- R1: After reset, the external-map flag and the tracked map-type bit are both 0. With no soft-switch write since reset, no address selects the RAM: `ram_cs_n` and `int_dis_n` stay 1.
- R2: A write in its data phase to address 0xFFBF sets the external-map flag from the next `clk` edge on. A read of 0xFFBF leaves the flag unchanged.
- R3: A write in its data phase to address 0xFFBE clears the external-map flag, which hands the upper range back to internal ROM (`ram_cs_n` = 1).
- R4: While the flag is 1 and the map type is 0, addresses 0x8000 to 0xFEFF inclusive select the RAM (`ram_cs_n` = 0). Addresses 0xFF00 and above are never selected.
- R5: Addresses below 0x8000 are never selected, whatever the flags hold.
- R6: A write in its data phase to 0xFFDF sets the tracked map type to 1, and a write to 0xFFDE sets it to 0. While the map type is 1, no address is selected, even with the flag set. The flag keeps its value across map-type changes.
- R7: `int_dis_n` is 0 exactly when `ram_cs_n` is 0.
- R8: `ram_we_n` is 0 only when the RAM is selected, `bus_rd_wr_n` is 0 and `bus_e` is 1.
- R9: `ram_addr` equals the bus address minus 0x8000, kept to 15 bits.
- R10: A write to any soft-switch address while `bus_e` is 0 changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for the soft-switch registers |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 16 | Host address bus |
| bus_rd_wr_n | input | 1 | 1 = read cycle, 0 = write cycle |
| bus_e | input | 1 | High during the data phase of a bus cycle |
| ram_cs_n | output | 1 | Active-low external RAM chip-select |
| ram_we_n | output | 1 | Active-low external RAM write-enable |
| ram_addr | output | 15 | Offset into the external RAM |
| int_dis_n | output | 1 | Active-low disable for internal ROM and device decoding |

## Verification
The hardest state to reach is an external map that was armed while the controller sat in map type 1. It is dormant and must come alive when map type 0 returns, with no new write to the arm address. The same reach is needed for the reverse case, where the flag is cleared while the map is dormant. Directed sequences walk through these orderings. A seeded random stream then mixes reads and writes, with and without the data phase, across the four switch addresses and the range boundaries 0x7FFF, 0x8000, 0xFEFF and 0xFF00. This lets flag combinations arise in orders the directed cases do not cover.

// File: rtl/cart_map_pkg.sv
package cart_map_pkg;
  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2
  } bus_cyc_e;

  function automatic bus_cyc_e classify_cycle(input logic rd_wr_n, input logic e);
    if (!e)           return CYC_IDLE;
    else if (rd_wr_n) return CYC_READ;
    else              return CYC_WRITE;
  endfunction
endpackage

// File: rtl/cart_soft_switch.sv
module cart_soft_switch #(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned SET_ADDR = 'hFFBF,
  parameter int unsigned CLR_ADDR = 'hFFBE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_strobe,
  input  logic [ADDR_W-1:0] addr,
  output logic              state
);
  localparam logic [ADDR_W-1:0] SET_A = ADDR_W'(SET_ADDR);
  localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'(CLR_ADDR);

  logic hit_set, hit_clr;
  assign hit_set = wr_strobe && (addr == SET_A);
  assign hit_clr = wr_strobe && (addr == CLR_A);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       state <= 1'b0;
    else if (hit_set) state <= 1'b1;
    else if (hit_clr) state <= 1'b0;
  end

  // R2 / R6: a qualified write to the set address turns the switch on
  p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_strobe && addr == SET_A) |=> state);
  // R3 / R6: a qualified write to the clear address turns it off
  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_strobe && addr == CLR_A) |=> !state);
  // R10: without a qualified write to either address the switch holds
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_strobe && (addr == SET_A || addr == CLR_A)) |=> $stable(state));
endmodule

// File: rtl/cart_addr_decode.sv
module cart_addr_decode #(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned OFS_W   = 15,
  parameter int unsigned RAM_LO  = 'h8000,
  parameter int unsigned RAM_HI  = 'hFEFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ext_on,
  input  logic              all_ram_map,
  input  logic              wr_data_phase,
  output logic              cs_n,
  output logic              we_n,
  output logic              dis_n,
  output logic [OFS_W-1:0]  ofs
);
  localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(RAM_LO);
  localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(RAM_HI);

  logic in_window, sel;
  assign in_window = (addr >= LO_A) && (addr <= HI_A);
  assign sel       = ext_on && !all_ram_map && in_window;

  assign cs_n  = !sel;
  assign dis_n = !sel;
  assign we_n  = !(sel && wr_data_phase);
  assign ofs   = OFS_W'(addr - LO_A);

  // R5: nothing below the window is ever claimed
  p_no_low_claim_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (addr < LO_A) |-> cs_n);
  // R4: the I/O page above the window is never claimed
  p_no_io_claim_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (addr > HI_A) |-> cs_n);
  // R6: map type 1 keeps the block silent
  p_maptype_inhibit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    all_ram_map |-> (cs_n && dis_n));
  // R7: the internal disable follows the chip-select
  p_dis_follows_cs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n == dis_n));
  // R8: a write strobe only appears inside a selected cycle
  p_we_qual_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (!cs_n && wr_data_phase));
endmodule

// File: rtl/cart_map_ctrl.sv
module cart_map_ctrl #(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned OFS_W   = 15,
  parameter int unsigned RAM_LO  = 'h8000,
  parameter int unsigned RAM_HI  = 'hFEFF,
  parameter int unsigned EXT_SET = 'hFFBF,
  parameter int unsigned EXT_CLR = 'hFFBE,
  parameter int unsigned MT_SET  = 'hFFDF,
  parameter int unsigned MT_CLR  = 'hFFDE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd_wr_n,
  input  logic              bus_e,
  output logic              ram_cs_n,
  output logic              ram_we_n,
  output logic [OFS_W-1:0]  ram_addr,
  output logic              int_dis_n
);
  import cart_map_pkg::*;

  bus_cyc_e cyc;
  logic     wr_phase;
  logic     ext_flag, map_type;

  assign cyc      = classify_cycle(bus_rd_wr_n, bus_e);
  assign wr_phase = (cyc == CYC_WRITE);

  cart_soft_switch #(.ADDR_W(ADDR_W), .SET_ADDR(EXT_SET), .CLR_ADDR(EXT_CLR)) u_ext_sw (
    .clk(clk), .rst_n(rst_n), .wr_strobe(wr_phase), .addr(bus_addr), .state(ext_flag)
  );

  cart_soft_switch #(.ADDR_W(ADDR_W), .SET_ADDR(MT_SET), .CLR_ADDR(MT_CLR)) u_mt_sw (
    .clk(clk), .rst_n(rst_n), .wr_strobe(wr_phase), .addr(bus_addr), .state(map_type)
  );

  cart_addr_decode #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .RAM_LO(RAM_LO), .RAM_HI(RAM_HI)) u_dec (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .ext_on(ext_flag), .all_ram_map(map_type),
    .wr_data_phase(wr_phase), .cs_n(ram_cs_n), .we_n(ram_we_n), .dis_n(int_dis_n), .ofs(ram_addr)
  );

  // R1: the first edge after reset still sees both flags clear
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!ext_flag && !map_type));
  // R10: a cycle outside the data phase never moves the external flag
  p_no_edge_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_e |=> $stable(ext_flag));
endmodule

// File: tb/test_cart_map_ctrl.sv
module test_cart_map_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = 16'h0000;
  logic        bus_rd_wr_n = 1'b1;
  logic        bus_e = 1'b0;
  logic        ram_cs_n, ram_we_n, int_dis_n;
  logic [14:0] ram_addr;

  int checks = 0;
  int failures = 0;
  bit m_flag = 1'b0;
  bit m_type = 1'b0;

  always #10 clk = ~clk;

  cart_map_ctrl i_cart_map_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd_wr_n(bus_rd_wr_n),
    .bus_e(bus_e), .ram_cs_n(ram_cs_n), .ram_we_n(ram_we_n),
    .ram_addr(ram_addr), .int_dis_n(int_dis_n)
  );

  function automatic bit exp_sel(input logic [15:0] a);
    return m_flag && !m_type && (a >= 16'h8000) && (a <= 16'hFEFF);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One bus cycle: drive at negedge, check the decode, then let the edge update flags.
  task automatic cycle(input logic [15:0] a, input logic rw, input logic e);
    bit s;
    @(negedge clk);
    bus_addr = a; bus_rd_wr_n = rw; bus_e = e;
    #2;
    s = exp_sel(a);
    chk(a < 16'h8000 ? "R5 cs" : (a > 16'hFEFF ? "R4 io cs" : (m_type ? "R6 cs" : "R4 cs")),
        {31'd0, ram_cs_n}, {31'd0, !s});
    chk("R7 dis", {31'd0, int_dis_n}, {31'd0, !s});
    chk("R8 we", {31'd0, ram_we_n}, {31'd0, !(s && !rw && e)});
    chk("R9 addr", {17'd0, ram_addr}, {17'd0, 15'(a - 16'h8000)});
    @(posedge clk);
    if (e && !rw) begin
      if (a == 16'hFFBF) m_flag = 1'b1;
      if (a == 16'hFFBE) m_flag = 1'b0;
      if (a == 16'hFFDF) m_type = 1'b1;
      if (a == 16'hFFDE) m_type = 1'b0;
    end
  endtask

  function automatic logic [15:0] pick_addr(input int unsigned r);
    case (r % 10)
      0: return 16'hFFBF;
      1: return 16'hFFBE;
      2: return 16'hFFDF;
      3: return 16'hFFDE;
      4: return 16'h7FFF;
      5: return 16'h8000;
      6: return 16'hFEFF;
      7: return 16'hFF00;
      default: return 16'($urandom());
    endcase
  endfunction

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd1234));
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1: nothing selected straight after reset
    @(negedge clk); bus_addr = 16'h9000; #2;
    chk("R1 cs after reset", {31'd0, ram_cs_n}, 32'd1);
    chk("R1 dis after reset", {31'd0, int_dis_n}, 32'd1);
    cycle(16'hC000, 1'b1, 1'b1);
    // R2: read of set address does nothing; write outside data phase does nothing (R10)
    cycle(16'hFFBF, 1'b1, 1'b1);
    cycle(16'hFFBF, 1'b0, 1'b0);
    @(negedge clk); bus_addr = 16'h8000; bus_e = 1'b0; #2;
    chk("R10 no arm without E", {31'd0, ram_cs_n}, 32'd1);
    // R2: arm, then range edges (R4, R5, R9)
    cycle(16'hFFBF, 1'b0, 1'b1);
    @(negedge clk); bus_addr = 16'h8000; bus_rd_wr_n = 1'b1; bus_e = 1'b0; #2;
    chk("R2 armed", {31'd0, ram_cs_n}, 32'd0);
    cycle(16'h7FFF, 1'b0, 1'b1);
    cycle(16'h8000, 1'b0, 1'b1);
    cycle(16'hFEFF, 1'b0, 1'b1);
    cycle(16'hFF00, 1'b0, 1'b1);
    cycle(16'hFFFF, 1'b1, 1'b1);
    cycle(16'hA5A5, 1'b0, 1'b0);
    // R6: map type 1 silences, flag survives, map type 0 revives
    cycle(16'hFFDF, 1'b0, 1'b1);
    cycle(16'h9000, 1'b0, 1'b1);
    cycle(16'hFFBE, 1'b0, 1'b1);
    cycle(16'hFFBF, 1'b0, 1'b1);
    cycle(16'hFFDE, 1'b0, 1'b1);
    @(negedge clk); bus_addr = 16'hD000; bus_e = 1'b0; #2;
    chk("R6 dormant flag revived", {31'd0, ram_cs_n}, 32'd0);
    // R3: clear returns ROM
    cycle(16'hFFBE, 1'b0, 1'b1);
    @(negedge clk); bus_addr = 16'hD000; bus_e = 1'b0; #2;
    chk("R3 cleared", {31'd0, ram_cs_n}, 32'd1);
    // seeded random mix
    for (int i = 0; i < 600; i++) begin
      cycle(pick_addr($urandom()), 1'($urandom()), 1'($urandom()));
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule